// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works out, in a single clock, what the processor state becomes when an exception is taken or when a handler returns. Seven request lines come in together: reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. The block also receives the current status word and the return address. One request wins under a fixed priority. Masked interrupts are dropped. The block then registers four results: the new status word, the copy to write into the banked saved status register, the link value and the vector PC.

A return request has the lowest priority. When it is granted, the status word is restored from the saved copy and the PC is restored from the link value. A `hi_vec` input moves the vector table from address zero to a high base that is set by a parameter. The register file, instruction decode and memory sit outside this block. They consume the registered outputs when `done` pulses.

Top module: `exc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every output becomes zero on that edge.
- R2: When an exception is taken, `spsr_out` equals the `cur_psr` value that was sampled, and `link_out` equals `ret_addr` unchanged.
- R3: The entry status word keeps every bit of `cur_psr` except the following. Bits 5 (T) and 24 (J) are cleared. Bits 4:0 take the target mode: 10011 for reset and software interrupt, 11011 for undefined, 10111 for either abort, 10010 for IRQ and 10001 for FIQ.
- R4: On entry, bit 7 (I) is set for every exception. Bit 6 (F) is set for reset and FIQ and keeps its old value otherwise.
- R5: The entry PC is the base plus 4 times the vector index. The indices are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6 and FIQ 7. The base is 0 when `hi_vec` is 0 and `HI_BASE` (default 0xFFFF0000) when it is 1. `vec_idx` reports the index.
- R6: Simultaneous requests are granted in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined/software interrupt.
- R7: IRQ is ignored while `cur_psr[7]` is 1, and FIQ is ignored while `cur_psr[6]` is 1. A masked request lets a lower-priority request win. If nothing else is pending, `done` stays low and the outputs hold.
- R8: A return that is granted gives `psr_out = saved_psr` and `pc_out = link_in`, with `is_return = 1`. Any granted exception in the same cycle takes precedence over the return.
- R9: `done` is high for exactly the cycle after each cycle in which a request was granted. Otherwise it is low and all other outputs hold their values.
- R10: When undefined instruction and software interrupt are requested together, undefined instruction wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| req_return | input | 1 | Handler return request |
| hi_vec | input | 1 | Select the high vector base |
| cur_psr | input | DW | Current status word |
| saved_psr | input | DW | Saved status word used on return |
| ret_addr | input | DW | Return address stored as link on entry |
| link_in | input | DW | Link value restored as PC on return |
| done | output | 1 | Pulse: a result is valid |
| is_return | output | 1 | The last result was a return |
| vec_idx | output | 3 | Vector index of the last exception |
| psr_out | output | DW | New status word |
| spsr_out | output | DW | Value to write into the saved status register |
| link_out | output | DW | Value to write into the link register |
| pc_out | output | DW | New program counter |

## Verification
Two functions can land in the same cycle: exception arbitration and a handler return. Mask filtering can also coincide with a fast-versus-normal interrupt race. The bench provokes both. It raises `req_return` together with an unmasked IRQ, then alone, and it raises FIQ and IRQ with only one mask bit set. A reference model in the bench predicts the registered results of every cycle, and these are compared with the outputs one clock later. A masked request can leave only a lower-priority request or nothing pending. In that case the model expects `done` to stay low and every output to keep its previous value.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    VEC_RST  = 3'd0,
    VEC_UND  = 3'd1,
    VEC_SWI  = 3'd2,
    VEC_PABT = 3'd3,
    VEC_DABT = 3'd4,
    VEC_RSVD = 3'd5,
    VEC_IRQ  = 3'd6,
    VEC_FIQ  = 3'd7
  } vec_e;

  localparam int NVEC   = 8;
  localparam int POS_J  = 24;
  localparam int POS_I  = 7;
  localparam int POS_F  = 6;
  localparam int POS_T  = 5;
  localparam int MODE_W = 5;

  function automatic logic [MODE_W-1:0] mode_of(input vec_e v);
    case (v)
      VEC_UND:            mode_of = 5'b11011;
      VEC_PABT, VEC_DABT: mode_of = 5'b10111;
      VEC_IRQ:            mode_of = 5'b10010;
      VEC_FIQ:            mode_of = 5'b10001;
      default:            mode_of = 5'b10011;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic [NVEC-1:0] req,
  input  logic            mask_i,
  input  logic            mask_f,
  output logic            take,
  output vec_e            sel
);
  // priority list, highest first in the low slot
  localparam int NPRI = 7;
  localparam logic [3*NPRI-1:0] ORDER =
    {3'd2, 3'd1, 3'd3, 3'd6, 3'd7, 3'd4, 3'd0};

  logic [NVEC-1:0] elig;

  always_comb begin
    elig          = req;
    elig[VEC_RSVD] = 1'b0;
    if (mask_i) elig[VEC_IRQ] = 1'b0;
    if (mask_f) elig[VEC_FIQ] = 1'b0;
  end

  always_comb begin
    take = 1'b0;
    sel  = VEC_RST;
    for (int i = NPRI-1; i >= 0; i--) begin
      if (elig[ORDER[3*i +: 3]]) begin
        take = 1'b1;
        sel  = vec_e'(ORDER[3*i +: 3]);
      end
    end
  end
endmodule

// File: rtl/exc_psr_builder.sv
module exc_psr_builder
  import exc_seq_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] HI_BASE = 32'hFFFF0000
) (
  input  vec_e          sel,
  input  logic [DW-1:0] cur_psr,
  input  logic          hi_vec,
  output logic [DW-1:0] psr_new,
  output logic [DW-1:0] pc_new
);
  localparam int VSHIFT = 2;

  logic [DW-1:0] base;

  generate
    if (HI_BASE == '0) begin : g_flat
      assign base = '0;
    end else begin : g_reloc
      assign base = hi_vec ? HI_BASE : '0;
    end
  endgenerate

  always_comb begin
    psr_new               = cur_psr;
    psr_new[POS_J]        = 1'b0;
    psr_new[POS_T]        = 1'b0;
    psr_new[POS_I]        = 1'b1;
    if (sel == VEC_RST || sel == VEC_FIQ)
      psr_new[POS_F]      = 1'b1;
    psr_new[MODE_W-1:0]   = mode_of(sel);
  end

  assign pc_new = base | (DW'(sel) << VSHIFT);
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] HI_BASE = 32'hFFFF0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_reset,
  input  logic          req_undef,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic          req_return,
  input  logic          hi_vec,
  input  logic [DW-1:0] cur_psr,
  input  logic [DW-1:0] saved_psr,
  input  logic [DW-1:0] ret_addr,
  input  logic [DW-1:0] link_in,
  output logic          done,
  output logic          is_return,
  output logic [2:0]    vec_idx,
  output logic [DW-1:0] psr_out,
  output logic [DW-1:0] spsr_out,
  output logic [DW-1:0] link_out,
  output logic [DW-1:0] pc_out
);
  logic [NVEC-1:0] req_vec;
  logic            take;
  vec_e            sel;
  logic [DW-1:0]   psr_new, pc_new;

  always_comb begin
    req_vec           = '0;
    req_vec[VEC_RST]  = req_reset;
    req_vec[VEC_UND]  = req_undef;
    req_vec[VEC_SWI]  = req_swi;
    req_vec[VEC_PABT] = req_pabt;
    req_vec[VEC_DABT] = req_dabt;
    req_vec[VEC_IRQ]  = req_irq;
    req_vec[VEC_FIQ]  = req_fiq;
  end

  exc_arbiter u_arb (
    .req    (req_vec),
    .mask_i (cur_psr[POS_I]),
    .mask_f (cur_psr[POS_F]),
    .take   (take),
    .sel    (sel)
  );

  exc_psr_builder #(.DW(DW), .HI_BASE(HI_BASE)) u_bld (
    .sel     (sel),
    .cur_psr (cur_psr),
    .hi_vec  (hi_vec),
    .psr_new (psr_new),
    .pc_new  (pc_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      is_return <= 1'b0;
      vec_idx   <= '0;
      psr_out   <= '0;
      spsr_out  <= '0;
      link_out  <= '0;
      pc_out    <= '0;
    end else begin
      done <= take | req_return;
      if (take) begin
        is_return <= 1'b0;
        vec_idx   <= sel;
        psr_out   <= psr_new;
        spsr_out  <= cur_psr;
        link_out  <= ret_addr;
        pc_out    <= pc_new;
      end else if (req_return) begin
        is_return <= 1'b1;
        psr_out   <= saved_psr;
        pc_out    <= link_in;
      end
    end
  end
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] HI_BASE = 32'hFFFF0000
) (
  input logic          clk,
  input logic          rst,
  input logic          req_reset,
  input logic          req_undef,
  input logic          req_swi,
  input logic          req_pabt,
  input logic          req_dabt,
  input logic          req_irq,
  input logic          req_fiq,
  input logic          req_return,
  input logic          hi_vec,
  input logic [DW-1:0] cur_psr,
  input logic [DW-1:0] saved_psr,
  input logic [DW-1:0] ret_addr,
  input logic [DW-1:0] link_in,
  input logic          done,
  input logic          is_return,
  input logic [2:0]    vec_idx,
  input logic [DW-1:0] psr_out,
  input logic [DW-1:0] spsr_out,
  input logic [DW-1:0] link_out,
  input logic [DW-1:0] pc_out
);
  // R2
  saved_copy_chk: assert property (@(posedge clk) disable iff (rst)
    done && !is_return |-> spsr_out == $past(cur_psr) && link_out == $past(ret_addr));

  // R3
  arm_state_chk: assert property (@(posedge clk) disable iff (rst)
    done && !is_return |-> !psr_out[5] && !psr_out[24]);

  // R4
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    done && !is_return |-> psr_out[7]);

  // R5
  vector_addr_chk: assert property (@(posedge clk) disable iff (rst)
    done && !is_return |-> pc_out[1:0] == 2'b00 && pc_out[4:2] == vec_idx &&
      pc_out[DW-1:5] == ($past(hi_vec) ? HI_BASE[DW-1:5] : '0));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    done && !is_return && vec_idx == 3'd6 |-> !$past(cur_psr[7]));

  // R7
  fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    done && !is_return && vec_idx == 3'd7 |-> !$past(cur_psr[6]));

  // R8
  ret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    done && is_return |-> psr_out == $past(saved_psr) && pc_out == $past(link_in));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_reset || req_undef || req_swi || req_pabt || req_dabt ||
           req_irq || req_fiq || req_return) |-> !done && $stable(pc_out));
endmodule

bind exc_sequencer exc_sequencer_chk #(.DW(DW), .HI_BASE(HI_BASE)) u_chk (
  .clk(clk), .rst(rst), .req_reset(req_reset), .req_undef(req_undef),
  .req_swi(req_swi), .req_pabt(req_pabt), .req_dabt(req_dabt),
  .req_irq(req_irq), .req_fiq(req_fiq), .req_return(req_return),
  .hi_vec(hi_vec), .cur_psr(cur_psr), .saved_psr(saved_psr),
  .ret_addr(ret_addr), .link_in(link_in), .done(done),
  .is_return(is_return), .vec_idx(vec_idx), .psr_out(psr_out),
  .spsr_out(spsr_out), .link_out(link_out), .pc_out(pc_out)
);

// File: tb/sim_exc_sequencer.sv
`timescale 1ns/1ps
module sim_exc_sequencer;
  localparam int DW = 32;

  logic clk = 0;
  logic rst;
  logic r_rst, r_und, r_swi, r_pabt, r_dabt, r_irq, r_fiq, r_ret, hi;
  logic [DW-1:0] cpsr, spsr_in, raddr, lnk;
  logic done, is_ret;
  logic [2:0] vidx;
  logic [DW-1:0] psr_o, spsr_o, link_o, pc_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic e_done, e_ret;
  logic [2:0] e_idx;
  logic [DW-1:0] e_psr, e_spsr, e_link, e_pc;

  always #4 clk = ~clk;

  exc_sequencer u0 (
    .clk(clk), .rst(rst), .req_reset(r_rst), .req_undef(r_und), .req_swi(r_swi),
    .req_pabt(r_pabt), .req_dabt(r_dabt), .req_irq(r_irq), .req_fiq(r_fiq),
    .req_return(r_ret), .hi_vec(hi), .cur_psr(cpsr), .saved_psr(spsr_in),
    .ret_addr(raddr), .link_in(lnk), .done(done), .is_return(is_ret),
    .vec_idx(vidx), .psr_out(psr_o), .spsr_out(spsr_o), .link_out(link_o),
    .pc_out(pc_o)
  );

  task automatic clear_in();
    {r_rst, r_und, r_swi, r_pabt, r_dabt, r_irq, r_fiq, r_ret} = '0;
  endtask

  task automatic model();
    int v;
    logic [DW-1:0] p;
    v = -1;
    if (rst) begin
      e_done = 0; e_ret = 0; e_idx = 0;
      e_psr = 0; e_spsr = 0; e_link = 0; e_pc = 0;
      return;
    end
    if (r_rst) v = 0;
    else if (r_dabt) v = 4;
    else if (r_fiq && !cpsr[6]) v = 7;
    else if (r_irq && !cpsr[7]) v = 6;
    else if (r_pabt) v = 3;
    else if (r_und) v = 1;
    else if (r_swi) v = 2;
    if (v >= 0) begin
      e_done = 1; e_ret = 0; e_idx = 3'(v);
      e_spsr = cpsr; e_link = raddr;
      e_pc = (hi ? 32'hFFFF0000 : 32'h0) + 32'(v * 4);
      p = cpsr; p[24] = 0; p[5] = 0; p[7] = 1;
      if (v == 0 || v == 7) p[6] = 1;
      case (v)
        1: p[4:0] = 5'b11011;
        3, 4: p[4:0] = 5'b10111;
        6: p[4:0] = 5'b10010;
        7: p[4:0] = 5'b10001;
        default: p[4:0] = 5'b10011;
      endcase
      e_psr = p;
    end else if (r_ret) begin
      e_done = 1; e_ret = 1; e_psr = spsr_in; e_pc = lnk;
    end else begin
      e_done = 0;
    end
  endtask

  // inputs already set at a negedge; model, clock, compare at next negedge
  task automatic cyc(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (done !== e_done || is_ret !== e_ret || vidx !== e_idx || psr_o !== e_psr ||
        spsr_o !== e_spsr || link_o !== e_link || pc_o !== e_pc) begin
      errors++;
      $display("FAIL %s: got done=%b ret=%b idx=%0d psr=%h spsr=%h link=%h pc=%h exp done=%b ret=%b idx=%0d psr=%h spsr=%h link=%h pc=%h",
               tag, done, is_ret, vidx, psr_o, spsr_o, link_o, pc_o,
               e_done, e_ret, e_idx, e_psr, e_spsr, e_link, e_pc);
    end
    clear_in();
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    hi = 0; rst = 1;
    cpsr = 32'hF100_0030; spsr_in = 32'h6000_001F; raddr = 32'h0000_1234; lnk = 32'h0000_8000;
    @(negedge clk);
    r_irq = 1; r_rst = 1;
    cyc("R1 reset clears outputs");
    cyc("R1 reset held");
    rst = 0;
    cyc("R9 idle after reset");

    // single exceptions from a user-mode word with T and J set, masks clear
    cpsr = 32'hF100_0030; raddr = 32'h0000_2004;
    r_rst = 1;  cyc("R3 R4 R5 reset entry");
    r_und = 1;  cyc("R3 R5 undefined entry");
    r_swi = 1;  cyc("R3 R5 swi entry");
    r_pabt = 1; cyc("R3 R5 prefetch abort entry");
    r_dabt = 1; cyc("R3 R5 data abort entry");
    r_irq = 1;  cyc("R4 R5 irq entry keeps F");
    r_fiq = 1;  cyc("R4 R5 fiq entry sets F");
    cyc("R9 done drops and outputs hold");

    // flags and Q preserved, link and saved copy
    cpsr = 32'h5800_0010; raddr = 32'hDEAD_BEEC;
    r_swi = 1; cyc("R2 saved copy and link");

    // high vectors
    hi = 1;
    r_irq = 1; cyc("R5 high vector irq");
    r_dabt = 1; cyc("R5 high vector dabt");
    hi = 0;

    // priority
    {r_rst, r_und, r_swi, r_pabt, r_dabt, r_irq, r_fiq} = '1; cyc("R6 reset wins all");
    {r_und, r_swi, r_pabt, r_dabt, r_irq, r_fiq} = '1;        cyc("R6 dabt over fiq");
    {r_und, r_swi, r_pabt, r_irq, r_fiq} = '1;                cyc("R6 fiq over irq");
    {r_und, r_swi, r_pabt, r_irq} = '1;                       cyc("R6 irq over pabt");
    {r_und, r_swi, r_pabt} = '1;                              cyc("R6 pabt over undef");
    r_und = 1; r_swi = 1;                                     cyc("R10 undef over swi");

    // masking
    cpsr = 32'h0000_0090;
    r_irq = 1; cyc("R7 masked irq ignored");
    r_irq = 1; r_swi = 1; cyc("R7 masked irq lets swi win");
    cpsr = 32'h0000_0050;
    r_fiq = 1; r_irq = 1; cyc("R7 masked fiq lets irq win");
    r_fiq = 1; cyc("R7 masked fiq ignored");
    cpsr = 32'h0000_00D0;
    r_rst = 1; cyc("R7 reset ignores masks");

    // return
    spsr_in = 32'h2000_0030; lnk = 32'h0000_4444;
    r_ret = 1; cyc("R8 return restores");
    cpsr = 32'h0000_0010;
    r_ret = 1; r_irq = 1; cyc("R8 exception beats return");
    r_ret = 1; cyc("R8 return after entry");
    cyc("R9 idle after return");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule